// File: doc/BRIEF.md
# Serial Peripheral Slave Front End with Hold

This block is the bit-level front end of a serial peripheral slave. It brings the serial clock, data input, active-low select and active-low hold pins into a faster system clock domain. It finds the serial clock edges there and assembles received bytes MSB first. It also shifts transmit bytes out on the data output pin, together with an output enable for an external tristate pad. Both clock idle levels are accepted. Input bits are taken on rising serial clock edges, and output bits change after falling edges.

A command controller sits beside the block. It receives each completed byte with a one-cycle strobe. It provides the next transmit byte, which the block captures in the cycle it raises its load request. That happens when select falls and again at each byte boundary. The hold pin pauses a transfer part-way through a byte. While paused, the output floats and clock or data activity is ignored. When the pause ends, the transfer continues from the same bit. Select going high always abandons any partial byte.

Top module: `spi_hold_frontend`

## Requirements
- R1: After reset, rx_valid_o, tx_load_o, miso_oe_o and miso_o are all 0.
- R2: With the serial clock idling low, eight rising edges under select low yield one rx_valid_o pulse of a single system cycle. rx_byte_o holds the eight data input bits in arrival order, with the first bit in bit 7.
- R3: With the serial clock idling high, reception and transmission behave exactly as in R2 and R4.
- R4: tx_byte_i is captured in every cycle where tx_load_o is 1. tx_load_o pulses once when select falls and once after each eighth rising edge. Bit 7 of the captured byte appears on miso_o before the first rising edge of the byte. Each following bit, in descending order, appears after a falling edge.
- R5: While select is high, miso_oe_o is 0 within three system cycles.
- R6: When hold goes low while the serial clock is low, miso_oe_o drops to 0. Serial clock and data transitions are then ignored. After hold returns high with the clock low, the byte completes from the bit where it stopped, with no bits lost or added.
- R7: A change of hold made while the serial clock is high has no effect on miso_oe_o until the clock goes low. A falling edge that ends such a high phase is still processed when it is entering hold. It is ignored when it is leaving hold.
- R8: Select going high mid-byte discards the partial byte with no rx_valid_o pulse. The next selection starts a fresh byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock pin |
| mosi_i | input | 1 | Serial data input pin |
| csn_i | input | 1 | Active-low select pin |
| holdn_i | input | 1 | Active-low hold pin |
| tx_byte_i | input | W | Next byte to transmit, captured when tx_load_o is 1 |
| rx_byte_o | output | W | Last complete received byte |
| rx_valid_o | output | 1 | One-cycle strobe when rx_byte_o is updated |
| tx_load_o | output | 1 | Transmit byte capture request |
| miso_o | output | 1 | Serial data output value |
| miso_oe_o | output | 1 | Output enable for the data output pad |

## Verification
Random bytes are sent in select sessions of one to three bytes. The clock idle level changes between sessions, which separates correct edge selection from a design that only works with one polarity. Hold pauses are placed at random bit positions, and the clock and data pins are toggled during each pause. A design that counts edges while paused, or that loses its shift state, then delivers a wrong byte. Directed cases add three things. Hold edges are placed inside a clock-high phase, which separates deferred from immediate hold. A select release after three bits shows that stale bits do not leak into the next byte. A running transmit-load count is compared against the model, which catches missing or extra captures.

// File: rtl/spi_hold_frontend.sv
module spi_hold_frontend #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sck_i,
  input  logic         mosi_i,
  input  logic         csn_i,
  input  logic         holdn_i,
  input  logic [W-1:0] tx_byte_i,
  output logic [W-1:0] rx_byte_o,
  output logic         rx_valid_o,
  output logic         tx_load_o,
  output logic         miso_o,
  output logic         miso_oe_o
);
  localparam int CW = $clog2(W);

  logic [1:0]    sck_sy, si_sy, cs_sy, hd_sy;
  logic          sck_s, si_s, cs_s, hd_s;
  logic          sck_q, cs_q, held, sor;
  logic [CW-1:0] bitcnt;
  logic [W-2:0]  shreg;
  logic [W-1:0]  txsh;
  logic          active, rise, fall, last, cs_fall;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_sy <= 2'b00;
      si_sy  <= 2'b00;
      cs_sy  <= 2'b11;
      hd_sy  <= 2'b11;
    end else begin
      sck_sy <= {sck_sy[0], sck_i};
      si_sy  <= {si_sy[0], mosi_i};
      cs_sy  <= {cs_sy[0], csn_i};
      hd_sy  <= {hd_sy[0], holdn_i};
    end

  assign sck_s   = sck_sy[1];
  assign si_s    = si_sy[1];
  assign cs_s    = cs_sy[1];
  assign hd_s    = hd_sy[1];

  assign active  = !cs_s && !held;
  assign rise    = active && sck_s && !sck_q;
  assign fall    = active && !sck_s && sck_q;
  assign last    = bitcnt == CW'(W-1);
  assign cs_fall = cs_q && !cs_s;

  assign tx_load_o = cs_fall || (rise && last);
  assign miso_oe_o = active;
  assign miso_o    = active && sor;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q      <= 1'b0;
      cs_q       <= 1'b1;
      held       <= 1'b0;
      bitcnt     <= '0;
      shreg      <= '0;
      rx_byte_o  <= '0;
      rx_valid_o <= 1'b0;
    end else begin
      sck_q      <= sck_s;
      cs_q       <= cs_s;
      rx_valid_o <= 1'b0;
      if (cs_s) begin
        held   <= 1'b0;
        bitcnt <= '0;
        shreg  <= '0;
      end else begin
        if (!sck_s) held <= !hd_s;
        if (rise) begin
          if (last) begin
            rx_byte_o  <= {shreg, si_s};
            rx_valid_o <= 1'b1;
            shreg      <= '0;
            bitcnt     <= '0;
          end else begin
            shreg  <= {shreg[W-3:0], si_s};
            bitcnt <= bitcnt + 1'b1;
          end
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      txsh <= '0;
      sor  <= 1'b0;
    end else begin
      if (tx_load_o) txsh <= tx_byte_i;
      if (cs_fall)   sor  <= tx_byte_i[W-1];
      else if (fall) sor  <= txsh[CW'(W-1) - bitcnt];
    end
endmodule

// File: rtl/spi_hold_frontend_chk.sv
module spi_hold_frontend_chk (
  input logic clk,
  input logic rst_n,
  input logic csn_i,
  input logic rx_valid_o,
  input logic tx_load_o,
  input logic miso_oe_o,
  input logic held,
  input logic sck_s,
  input logic cs_s
);
  assert_oe_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    csn_i |=> ##1 !miso_oe_o);

  assert_rx_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);

  assert_load_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load_o |=> !tx_load_o);

  assert_hold_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    held |=> !rx_valid_o);

  assert_hold_defer_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_s && !cs_s) |=> $stable(held));

  assert_no_partial_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !rx_valid_o);
endmodule

bind spi_hold_frontend spi_hold_frontend_chk u_chk (
  .clk(clk), .rst_n(rst_n), .csn_i(csn_i), .rx_valid_o(rx_valid_o),
  .tx_load_o(tx_load_o), .miso_oe_o(miso_oe_o), .held(held),
  .sck_s(sck_s), .cs_s(cs_s)
);

// File: tb/tb_spi_hold_frontend.sv
`timescale 1ns/1ps
module tb_spi_hold_frontend;
  logic clk = 0, rst_n = 0;
  logic sck = 0, mosi = 0, csn = 1, holdn = 1;
  logic [7:0] tx_byte, rx_byte;
  logic rx_valid, tx_load, miso, miso_oe;
  int checks = 0, errors = 0;
  int ld_idx = 0, exp_ld = 0, rxn = 0;
  logic [7:0] rxq [0:255];

  always #2 clk = ~clk;

  spi_hold_frontend dut (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .mosi_i(mosi), .csn_i(csn),
    .holdn_i(holdn), .tx_byte_i(tx_byte), .rx_byte_o(rx_byte),
    .rx_valid_o(rx_valid), .tx_load_o(tx_load), .miso_o(miso),
    .miso_oe_o(miso_oe)
  );

  function automatic logic [7:0] txpat(int i);
    return 8'(i * 37 + 11);
  endfunction

  assign tx_byte = txpat(ld_idx);
  always @(posedge clk) if (tx_load) ld_idx <= ld_idx + 1;
  always @(negedge clk) if (rx_valid && rxn < 256) begin rxq[rxn] = rx_byte; rxn++; end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_on(bit mode);
    csn = 1; sck = mode; w(8);
    csn = 0; w(8);
  endtask

  task automatic cs_off();
    csn = 1; w(8);
    chk(!miso_oe, "R5", miso_oe, 0);
  endtask

  task automatic do_hold();
    int r0;
    r0 = rxn;
    w(4); holdn = 0; w(8);
    chk(!miso_oe, "R6", miso_oe, 0);
    repeat (3) begin
      mosi = ~mosi; sck = 1; w(8);
      mosi = ~mosi; sck = 0; w(8);
    end
    chk(rxn == r0, "R6", rxn, r0);
    holdn = 1; w(8);
    chk(miso_oe, "R6", miso_oe, 1);
  endtask

  task automatic bit_x(bit mode, bit mb, bit sb);
    if (mode) sck = 0;
    mosi = mb; w(8);
    chk(miso === sb && miso_oe, mode ? "R3" : "R4", miso, sb);
    sck = 1; w(8);
    if (!mode) sck = 0;
  endtask

  task automatic defer_bit(bit mb, bit sb);
    mosi = mb; w(8);
    chk(miso === sb && miso_oe, "R4", miso, sb);
    sck = 1; w(2); holdn = 0; w(8);
    chk(miso_oe, "R7", miso_oe, 1);
    sck = 0; w(8);
    chk(!miso_oe, "R7", miso_oe, 0);
    sck = 1; w(4); holdn = 1; w(8);
    chk(!miso_oe, "R7", miso_oe, 0);
    sck = 0; w(8);
    chk(miso_oe, "R7", miso_oe, 1);
  endtask

  task automatic xfer(bit mode, logic [7:0] mb, logic [7:0] sb, int hkind, int hbit);
    for (int i = 7; i >= 0; i--) begin
      if (!mode && hkind == 1 && i == hbit) do_hold();
      if (!mode && hkind == 2 && i == hbit) defer_bit(mb[i], sb[i]);
      else bit_x(mode, mb[i], sb[i]);
    end
  endtask

  task automatic sess(bit mode, int n, int hkind, int hbit);
    cs_on(mode);
    for (int j = 0; j < n; j++) begin
      logic [7:0] m;
      int r0;
      m = 8'($urandom);
      r0 = rxn;
      xfer(mode, m, txpat(exp_ld + j), j == 0 ? hkind : 0, hbit);
      w(2);
      chk(rxn == r0 + 1, mode ? "R3" : "R2", rxn, r0 + 1);
      chk(rxq[r0] == m, mode ? "R3" : (hkind != 0 && j == 0 ? "R6" : "R2"), rxq[r0], m);
    end
    cs_off();
    exp_ld += n + 1;
    chk(ld_idx == exp_ld, "R4", ld_idx, exp_ld);
  endtask

  initial begin
    void'($urandom(32'd4242));
    w(4);
    chk(!rx_valid && !tx_load && !miso_oe && !miso, "R1",
        {rx_valid, tx_load, miso_oe, miso}, 0);
    rst_n = 1; w(4);
    chk(!rx_valid && !tx_load && !miso_oe, "R1", {rx_valid, tx_load, miso_oe}, 0);

    sess(0, 2, 0, 0);
    sess(1, 2, 0, 0);
    sess(0, 1, 1, 4);
    sess(0, 1, 1, 0);
    sess(0, 2, 2, 3);

    begin
      int r0;
      logic [7:0] s;
      r0 = rxn;
      s = txpat(exp_ld);
      cs_on(0);
      for (int i = 7; i >= 5; i--) bit_x(0, 1'b1, s[i]);
      cs_off();
      exp_ld += 1;
      chk(rxn == r0, "R8", rxn, r0);
      chk(ld_idx == exp_ld, "R8", ld_idx, exp_ld);
      sess(0, 1, 0, 0);
    end

    for (int k = 0; k < 20; k++) begin
      bit md;
      md = 1'($urandom % 2);
      sess(md, 1 + int'($urandom % 3), (!md && ($urandom % 2)) ? 1 : 0, int'($urandom % 8));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule